// File: doc/BRIEF.md
# Inter-Core Doorbell Register Block

This block is a small register file on a plain synchronous write bus with combinational read-back. It lets two processor cores and an external host signal each other. Each target (core 0, core 1, host) owns a set of 28 source flags. Software sets the flags through the target's raise register and clears them through the target's acknowledge register. Both registers read back the same flags, so the receiver can tell which senders called it.

Setting bit 0 of a raise register fires a doorbell:
- For a core, the doorbell is a single-cycle pulse.
- For the host, the doorbell is a stretched pulse: high for four cycles, then low for four. No new host doorbell is accepted during those eight cycles.

A separate per-core register fires a single-cycle non-maskable event.

The bus has no back-pressure. A write is taken in the cycle `bus_wen` is high, and a read returns data in the same cycle from `bus_addr`. There is no valid/ready handshake, because every access completes at once.

Top module: `doorbell_regs`

## Requirements
- R1: During and right after reset, `core_irq`, `core_nmi` and `host_irq` are low and every address reads 0.
- R2: A write with bit 0 = 1 to a core raise register (addr `{2'b00, slot}`, slot 0 = core 0, slot 1 = core 1) drives that core's `core_irq` bit high for exactly the one cycle after the write edge. Bit 0 = 0 gives no pulse, and the other core's bit stays low.
- R3: In a raise register, writing 1 to a data bit 31:4 sets that source flag and writing 0 leaves it unchanged. The raise and acknowledge registers of the same slot read the same flags.
- R4: Writing 1 to a bit 31:4 of an acknowledge register (addr `{2'b01, slot}`) clears that flag, and writing 0 keeps it. A write to an acknowledge register never produces a pulse.
- R5: Raise and acknowledge registers read bits 3:0 as zero.
- R6: A write with bit 0 = 1 to a non-maskable register (addr `{2'b10, slot}`, slot 0 or 1) pulses that core's `core_nmi` bit for one cycle. Bit 0 = 0 has no effect, and these addresses read 0.
- R7: The host slot (slot 2) sets and clears flags the same way as the core slots. Its doorbell appears on `host_irq` and not on `core_irq`.
- R8: An accepted host doorbell makes `host_irq` high for HOST_HI = 4 cycles from the cycle after the write edge, then low for HOST_LO = 4 cycles.
- R9: A host doorbell write within the 7 cycles after an accepted one (write edges t+1 to t+7) is ignored. A write at t+8 or later is accepted. Flags in an ignored write are still set.
- R10: Addresses outside the map (kind 3, or slot 3) read 0, and writes to them change no flag and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Word address: kind in [3:2], slot in [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| core_irq | output | 2 | Per-core doorbell pulse |
| core_nmi | output | 2 | Per-core non-maskable event pulse |
| host_irq | output | 1 | Stretched host doorbell |

## Verification
On every cycle, assertions check four things:
- Flag updates: a set bit sticks, a clear with no set removes the bit, and with no write the flags hold.
- Every core or non-maskable pulse traces back to a write with bit 0 set.
- Each host pulse is exactly four cycles wide.
- Each host pulse rise follows at least four low cycles.

Only the bench scenarios can show the rest:
- The address decode and the read-back values.
- That a doorbell to one core leaves the other quiet.
- The exact retrigger boundary of the host lockout.
- That flags carried by an ignored host write are still recorded.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  // Register kind carried in the upper address bits.
  typedef enum logic [1:0] {
    KIND_RAISE = 2'd0,
    KIND_ACK   = 2'd1,
    KIND_NMI   = 2'd2,
    KIND_NONE  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/doorbell_src_bank.sv
module doorbell_src_bank #(
  parameter int SRC_BITS = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic                clr_en,
  input  logic [SRC_BITS-1:0] wbits,
  output logic [SRC_BITS-1:0] src_q
);
  logic [SRC_BITS-1:0] set_mask, clr_mask;

  assign set_mask = set_en ? wbits : '0;
  assign clr_mask = clr_en ? wbits : '0;

  // A set overrides a clear on the same bit.
  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= (src_q & ~clr_mask) | set_mask;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((src_q & $past(wbits)) == $past(wbits))); // R3
  AST_CLR_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((src_q & $past(wbits)) == '0)); // R4
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(src_q)); // R3
endmodule

// File: rtl/doorbell_host_shaper.sv
module doorbell_host_shaper #(
  parameter int HOST_HI = 4,
  parameter int HOST_LO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic host_irq
);
  localparam int PERIOD = HOST_HI + HOST_LO;
  localparam int CNT_W  = $clog2(PERIOD + 1);
  localparam int RUN_W  = $clog2(PERIOD + 1) + 1;

  logic [CNT_W-1:0] phase_q;
  logic             idle, last_phase, accept;

  assign idle       = (phase_q == '0);
  assign last_phase = (phase_q == CNT_W'(PERIOD));
  assign accept     = trigger && (idle || last_phase);

  always_ff @(posedge clk) begin
    if (!rst_n)          phase_q <= '0;
    else if (accept)     phase_q <= CNT_W'(1);
    else if (last_phase) phase_q <= '0;
    else if (!idle)      phase_q <= phase_q + CNT_W'(1);
  end

  assign host_irq = !idle && (phase_q <= CNT_W'(HOST_HI));

  // Observation counters for the shape checks.
  logic [RUN_W-1:0] hi_run_q, lo_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run_q <= '0;
      lo_run_q <= RUN_W'(HOST_LO);
    end else if (host_irq) begin
      hi_run_q <= (hi_run_q == RUN_W'(PERIOD)) ? hi_run_q : hi_run_q + RUN_W'(1);
      lo_run_q <= '0;
    end else begin
      hi_run_q <= '0;
      lo_run_q <= (lo_run_q == RUN_W'(PERIOD)) ? lo_run_q : lo_run_q + RUN_W'(1);
    end
  end

  AST_HOST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_irq) |-> (hi_run_q == RUN_W'(HOST_HI))); // R8
  AST_HOST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> (lo_run_q >= RUN_W'(HOST_LO))); // R9
endmodule

// File: rtl/doorbell_regs.sv
module doorbell_regs
  import doorbell_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int DATA_W    = 32,
  parameter int SRC_BITS  = 28,
  parameter int HOST_HI   = 4,
  parameter int HOST_LO   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wen,
  input  logic [1+$clog2(NUM_CORES+1):0] bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [NUM_CORES-1:0]     core_irq,
  output logic [NUM_CORES-1:0]     core_nmi,
  output logic                     host_irq
);
  localparam int SLOTS   = NUM_CORES + 1;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int ADDR_W  = SLOT_W + 2;
  localparam int SRC_LSB = DATA_W - SRC_BITS;
  localparam int HOST    = NUM_CORES;

  reg_kind_e           kind;
  logic [SLOT_W-1:0]   slot;
  logic [SRC_BITS-1:0] wbits;
  logic [SRC_BITS-1:0] src_arr [SLOTS];
  logic [SLOTS-1:0]    raise_hit, ack_hit;
  logic                unused_wbits;

  assign kind         = reg_kind_e'(bus_addr[ADDR_W-1:SLOT_W]);
  assign slot         = bus_addr[SLOT_W-1:0];
  assign wbits        = bus_wdata[DATA_W-1:SRC_LSB];
  assign unused_wbits = ^bus_wdata[SRC_LSB-1:1];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign raise_hit[s] = bus_wen && (kind == KIND_RAISE) && (slot == SLOT_W'(s));
    assign ack_hit[s]   = bus_wen && (kind == KIND_ACK)   && (slot == SLOT_W'(s));

    doorbell_src_bank #(.SRC_BITS(SRC_BITS)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (raise_hit[s]),
      .clr_en (ack_hit[s]),
      .wbits  (wbits),
      .src_q  (src_arr[s])
    );
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic nmi_hit;
    assign nmi_hit = bus_wen && (kind == KIND_NMI) && (slot == SLOT_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        core_irq[c] <= 1'b0;
        core_nmi[c] <= 1'b0;
      end else begin
        core_irq[c] <= raise_hit[c] && bus_wdata[0];
        core_nmi[c] <= nmi_hit && bus_wdata[0];
      end
    end

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      core_irq[c] |-> $past(bus_wen && bus_wdata[0])); // R2
    AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      core_nmi[c] |-> $past(bus_wen && bus_wdata[0])); // R6
  end

  doorbell_host_shaper #(.HOST_HI(HOST_HI), .HOST_LO(HOST_LO)) u_host (
    .clk      (clk),
    .rst_n    (rst_n),
    .trigger  (raise_hit[HOST] && bus_wdata[0]),
    .host_irq (host_irq)
  );

  always_comb begin
    bus_rdata = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if ((kind == KIND_RAISE || kind == KIND_ACK) && slot == SLOT_W'(s))
        bus_rdata = {src_arr[s], {SRC_LSB{1'b0}}};
    end
  end
endmodule

// File: tb/sim_doorbell_regs.sv
module sim_doorbell_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wen = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  core_irq, core_nmi;
  logic        host_irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  doorbell_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_wen(wen), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .core_irq(core_irq),
    .core_nmi(core_nmi), .host_irq(host_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wen = 1'b1; addr = a; wdata = d;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp_src [3];
    logic [31:0] pat;
    int highs;
    for (int i = 0; i < 3; i++) exp_src[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {27'd0, core_irq, core_nmi, host_irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], v); chk("R1 read after reset", v, 32'd0);
    end

    // R2: core doorbells
    wr(4'h0, 32'h1);
    chk("R2 core0 pulse", {30'd0, core_irq}, 32'd1);
    @(negedge clk);
    chk("R2 core0 pulse ends", {30'd0, core_irq}, 32'd0);
    wr(4'h1, 32'h1);
    chk("R2 core1 pulse", {30'd0, core_irq}, 32'd2);
    chk("R2 no host pulse", {31'd0, host_irq}, 32'd0);
    @(negedge clk);
    chk("R2 core1 pulse ends", {30'd0, core_irq}, 32'd0);
    wr(4'h0, 32'h0);
    chk("R2 bit0 clear no pulse", {30'd0, core_irq}, 32'd0);

    // R3, R4, R7: per-bit set then pattern clear on every slot
    for (int s = 0; s < 3; s++) begin
      for (int b = 0; b < 28; b++) begin
        wr(s[3:0], 32'd1 << (b + 4));
        exp_src[s] = exp_src[s] | (32'd1 << (b + 4));
        rd(s[3:0], v);        chk("R3 raise reads flags", v, exp_src[s]);
        rd(4'h4 + s[3:0], v); chk("R3 ack reads flags", v, exp_src[s]);
      end
      wr(s[3:0], 32'h0);
      rd(s[3:0], v); chk("R3 zero write keeps", v, exp_src[s]);
      pat = 32'h5A5A_5A50 ^ (32'h1111_1110 * s);
      wr(4'h4 + s[3:0], pat);
      exp_src[s] = exp_src[s] & ~pat;
      chk("R4 ack no pulse", {29'd0, core_irq, host_irq}, 32'd0);
      rd(s[3:0], v);        chk("R4 raise after clear", v, exp_src[s]);
      rd(4'h4 + s[3:0], v); chk("R4 ack after clear", v, exp_src[s]);
      wr(4'h4 + s[3:0], 32'h0);
      rd(s[3:0], v); chk("R4 zero ack keeps", v, exp_src[s]);
      wr(4'h4 + s[3:0], 32'hFFFF_FFF0);
      exp_src[s] = '0;
      rd(4'h4 + s[3:0], v); chk("R7 slot cleared", v, 32'd0);
    end

    // R5: low bits read zero
    wr(4'h0, 32'hFFFF_FFFF);
    chk("R5 pulse with all ones", {30'd0, core_irq}, 32'd1);
    rd(4'h0, v); chk("R5 low bits zero", v, 32'hFFFF_FFF0);
    rd(4'h4, v); chk("R5 ack low bits zero", v, 32'hFFFF_FFF0);
    rd(4'h1, v); chk("R3 other core untouched", v, 32'd0);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R4 full clear", v, 32'd0);

    // R6: non-maskable events
    wr(4'h8, 32'h1);
    chk("R6 nmi core0", {30'd0, core_nmi}, 32'd1);
    chk("R6 no irq", {30'd0, core_irq}, 32'd0);
    @(negedge clk);
    chk("R6 nmi ends", {30'd0, core_nmi}, 32'd0);
    wr(4'h9, 32'h1);
    chk("R6 nmi core1", {30'd0, core_nmi}, 32'd2);
    wr(4'h9, 32'hFFFF_FFFE);
    chk("R6 zero bit no nmi", {30'd0, core_nmi}, 32'd0);
    rd(4'h8, v); chk("R6 nmi reads zero", v, 32'd0);
    rd(4'h9, v); chk("R6 nmi reads zero", v, 32'd0);

    // R10: unmapped addresses
    wr(4'h3, 32'hFFFF_FFF1);
    wr(4'hC, 32'hFFFF_FFF1);
    chk("R10 no pulses", {27'd0, core_irq, core_nmi, host_irq}, 32'd0);
    for (int s = 0; s < 3; s++) begin
      rd(s[3:0], v); chk("R10 flags untouched", v, 32'd0);
    end
    rd(4'h3, v); chk("R10 unmapped read", v, 32'd0);
    rd(4'hE, v); chk("R10 unmapped read", v, 32'd0);

    // R8, R9: host pulse shape and lockout sweep
    wr(4'h2, 32'h1);
    for (int t = 0; t < 8; t++) begin
      chk("R8 host shape", {31'd0, host_irq}, (t < 4) ? 32'd1 : 32'd0);
      @(negedge clk);
    end
    for (int d = 1; d <= 12; d++) begin
      repeat (10) @(negedge clk);
      highs = 0;
      for (int t = 0; t <= 20; t++) begin
        @(negedge clk);
        if (t > 0 && host_irq) highs++;
        if (t == 0 || t == d) begin
          wen = 1'b1; addr = 4'h2;
          wdata = (t == 0) ? 32'h1 : ((32'd1 << (d + 4)) | 32'h1);
        end else begin
          wen = 1'b0;
        end
      end
      wen = 1'b0;
      exp_src[2] = exp_src[2] | (32'd1 << (d + 4));
      chk((d < 8) ? "R9 retrigger ignored" : "R8 retrigger accepted",
          highs, (d < 8) ? 32'd4 : 32'd8);
      rd(4'h2, v); chk("R9 flags recorded", v, exp_src[2]);
    end
    chk("R7 host pulses not on cores", {30'd0, core_irq}, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule